// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the power-state controller of a small chip. Software runs in the Active state and asks for a reduced-power state by presenting a two-bit mode code with a valid strobe. The sequencer then drives the gating outputs for that state: the CPU clock enable, the shared peripheral clock enable, the per-peripheral clock gates, the main oscillator enable, the core power enable, and the two retention enables for SRAM and the 32 kHz oscillator. It watches interrupt requests, capture interrupts and up to three external wake lines, and returns the chip to Active along the exit path that belongs to the current state.

The FSM has six states. ST_ACTIVE runs everything. ST_IDLE stops only the CPU clock. ST_PDOWN stops the oscillator and every clock. ST_SETTLE restarts the oscillator and waits out a programmable count before the clocks come back. ST_DEEP removes core power. ST_WAKE_RST restores power and the oscillator, holds a full-reset request for the count, and then releases the chip. The named transitions are: ACTIVE->IDLE, ACTIVE->PDOWN and ACTIVE->DEEP on an accepted request; IDLE->ACTIVE on any interrupt; PDOWN->SETTLE and DEEP->WAKE_RST on an enabled external wake line; SETTLE->ACTIVE and WAKE_RST->ACTIVE when the count expires; any state->ACTIVE on reset.

Three general-purpose retention registers sit in an always-on domain. The power-on reset clears them. The sequencer reset and the wake reset do not.

Top module: `pwr_mode_seq`

## Requirements
- R1: After `rst_n` is released, the block is in Active. `cpu_clk_en`, `per_clk_en`, `osc_en`, `core_pwr_en`, `sram_ret_en` and `rtc_osc_en` are 1, `full_rst_req` is 0, and `per_clk_gate` equals `periph_en`.
- R2: Mode codes on `req_mode` are 1 for Idle, 2 for Power-down and 3 for Deep power-down. Code 0 is ignored. A request with `req_valid` high is accepted only in Active, and the new state shows on the outputs after the next clock edge. An Idle request is refused while any interrupt source is high. A Power-down or Deep power-down request is refused while an enabled external wake line is high.
- R3: In Idle, `cpu_clk_en` is 0 and the peripheral clock, oscillator, core power and retention enables are 1. Any high bit of `irq` or `cap_irq`, or an enabled external wake line, returns the block to Active after the next edge.
- R4: In Power-down, `osc_en`, `cpu_clk_en` and `per_clk_en` are 0, and `core_pwr_en`, `sram_ret_en` and `rtc_osc_en` are 1. Only an external line with its bit in `ext_wake_en` set can wake the block. `irq`, `cap_irq` and unenabled lines have no effect.
- R5: A wake from Power-down first raises `osc_en` with all clocks still off. This lasts exactly N cycles, where N is `settle_cnt` clamped to the range 4 to 4096. The block then returns to Active.
- R6: In Deep power-down, `core_pwr_en`, `osc_en` and all clock enables are 0. `sram_ret_en` and `rtc_osc_en` take the values that `keep_sram` and `keep_rtc_osc` had when the request was accepted. Later changes to those inputs have no effect.
- R7: Deep power-down is left only through an enabled external wake line. The exit raises `full_rst_req`, `core_pwr_en` and `osc_en` with clocks off for exactly N cycles (N as in R5), and then returns to Active.
- R8: `per_clk_gate` equals `periph_en` in Active and Idle, and is all zeros in every other state.
- R9: A write through `gpr_we`/`gpr_sel`/`gpr_wdata` lands only while `cpu_clk_en` is 1. The retention registers keep their contents across `rst_n` pulses and Deep power-down, and only `por_n` clears them. Slot i reads on `gpr_rdata[i*32 +: 32]`.
- R10: Asserting `rst_n` in any state forces the Active outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low sequencer reset |
| por_n | input | 1 | Power-on reset for the always-on retention registers |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode code (1 Idle, 2 Power-down, 3 Deep) |
| keep_sram | input | 1 | Keep SRAM powered in Deep power-down |
| keep_rtc_osc | input | 1 | Keep 32 kHz oscillator running in Deep power-down |
| settle_cnt | input | 13 | Oscillator settle count, clamped to 4..4096 |
| irq | input | 8 | Enabled interrupt requests |
| cap_irq | input | 10 | Capture-derived interrupts (never wake from Power-down) |
| ext_wake | input | 3 | External interrupt lines |
| ext_wake_en | input | 3 | Wake-capable flag per external line |
| periph_en | input | 8 | Per-peripheral clock enable bits |
| gpr_we | input | 1 | Retention register write strobe |
| gpr_sel | input | 2 | Retention register index |
| gpr_wdata | input | 32 | Retention register write data |
| gpr_rdata | output | 96 | All retention registers, slot i at bits i*32 upward |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Shared peripheral clock enable |
| per_clk_gate | output | 8 | Per-peripheral clock gates |
| osc_en | output | 1 | Main oscillator enable |
| core_pwr_en | output | 1 | Core logic power enable |
| sram_ret_en | output | 1 | SRAM power enable |
| rtc_osc_en | output | 1 | 32 kHz oscillator enable |
| full_rst_req | output | 1 | Full chip reset request during Deep exit |

## Verification
The assertions check the invariants that must hold on every cycle. With no oscillator, no clock may run. With core power off, no clock and no reset request may be active. The gates are closed whenever the peripheral clock is off. A rising oscillator enable never arrives together with a clock. Power-down and Deep power-down are held as long as no enabled wake line is high. A pending wake blocks entry. An interrupt in Idle always reaches Active. Only the bench scenarios can show the exact settle length and its clamping at both ends, the sampling of the retention choices at entry, and how the retention registers behave across resets and power states.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE   = 3'd0,
        ST_IDLE     = 3'd1,
        ST_PDOWN    = 3'd2,
        ST_SETTLE   = 3'd3,
        ST_DEEP     = 3'd4,
        ST_WAKE_RST = 3'd5
    } pwr_state_e;

    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_IDLE  = 2'd1,
        REQ_PDOWN = 2'd2,
        REQ_DEEP  = 2'd3
    } pwr_req_e;

    typedef struct packed {
        logic cpu_clk;
        logic per_clk;
        logic osc;
        logic core_pwr;
        logic sram_ret;
        logic rtc_osc;
        logic rst_req;
    } pwr_ctl_t;

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
    parameter int NUM_EXT = 3,
    parameter int NUM_IRQ = 8,
    parameter int NUM_CAP = 10
) (
    input  logic [NUM_EXT-1:0] ext_wake,
    input  logic [NUM_EXT-1:0] ext_wake_en,
    input  logic [NUM_IRQ-1:0] irq,
    input  logic [NUM_CAP-1:0] cap_irq,
    output logic               clkless_wake,
    output logic               any_wake
);
    logic [NUM_EXT-1:0] ext_hit;

    // Only flagged external lines work without clocks; capture never qualifies.
    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
        assign ext_hit[i] = ext_wake[i] & ext_wake_en[i];
    end

    assign clkless_wake = |ext_hit;
    assign any_wake     = clkless_wake | (|irq) | (|cap_irq);
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int SETTLE_MIN = 4,
    parameter int SETTLE_MAX = 4096,
    parameter int CW         = $clog2(SETTLE_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] eff;

    always_comb begin
        if (limit < CW'(SETTLE_MIN))      eff = CW'(SETTLE_MIN);
        else if (limit > CW'(SETTLE_MAX)) eff = CW'(SETTLE_MAX);
        else                              eff = limit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= eff - CW'(1);
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pwr_ret_regs.sv
module pwr_ret_regs #(
    parameter int NUM_GPR = 3,
    parameter int GPR_W   = 32,
    parameter int SEL_W   = (NUM_GPR > 1) ? $clog2(NUM_GPR) : 1
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [GPR_W-1:0]         wr_data,
    output logic [NUM_GPR*GPR_W-1:0] rd_flat
);
    for (genvar i = 0; i < NUM_GPR; i++) begin : g_slot
        logic [GPR_W-1:0] q;
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)                               q <= '0;
            else if (wr_en && (wr_sel == SEL_W'(i)))  q <= wr_data;
        end
        assign rd_flat[i*GPR_W +: GPR_W] = q;
    end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int NUM_EXT    = 3,
    parameter int NUM_IRQ    = 8,
    parameter int NUM_CAP    = 10,
    parameter int NUM_PERIPH = 8,
    parameter int NUM_GPR    = 3,
    parameter int GPR_W      = 32,
    parameter int SETTLE_MIN = 4,
    parameter int SETTLE_MAX = 4096,
    localparam int CW        = $clog2(SETTLE_MAX + 1),
    localparam int SEL_W     = (NUM_GPR > 1) ? $clog2(NUM_GPR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     por_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_mode,
    input  logic                     keep_sram,
    input  logic                     keep_rtc_osc,
    input  logic [CW-1:0]            settle_cnt,
    input  logic [NUM_IRQ-1:0]       irq,
    input  logic [NUM_CAP-1:0]       cap_irq,
    input  logic [NUM_EXT-1:0]       ext_wake,
    input  logic [NUM_EXT-1:0]       ext_wake_en,
    input  logic [NUM_PERIPH-1:0]    periph_en,
    input  logic                     gpr_we,
    input  logic [SEL_W-1:0]         gpr_sel,
    input  logic [GPR_W-1:0]         gpr_wdata,
    output logic [NUM_GPR*GPR_W-1:0] gpr_rdata,
    output logic                     cpu_clk_en,
    output logic                     per_clk_en,
    output logic [NUM_PERIPH-1:0]    per_clk_gate,
    output logic                     osc_en,
    output logic                     core_pwr_en,
    output logic                     sram_ret_en,
    output logic                     rtc_osc_en,
    output logic                     full_rst_req
);
    pwr_state_e state, state_nxt;
    pwr_ctl_t   ctl;
    pwr_req_e   req_code;
    logic       clkless_wake, any_wake;
    logic       settle_load, settle_done;
    logic       keep_sram_q, keep_rtc_q;

    pwr_wake_qual #(
        .NUM_EXT(NUM_EXT), .NUM_IRQ(NUM_IRQ), .NUM_CAP(NUM_CAP)
    ) u_wake (
        .ext_wake    (ext_wake),
        .ext_wake_en (ext_wake_en),
        .irq         (irq),
        .cap_irq     (cap_irq),
        .clkless_wake(clkless_wake),
        .any_wake    (any_wake)
    );

    pwr_settle_timer #(
        .SETTLE_MIN(SETTLE_MIN), .SETTLE_MAX(SETTLE_MAX), .CW(CW)
    ) u_settle (
        .clk  (clk),
        .rst_n(rst_n),
        .load (settle_load),
        .limit(settle_cnt),
        .done (settle_done)
    );

    pwr_ret_regs #(
        .NUM_GPR(NUM_GPR), .GPR_W(GPR_W), .SEL_W(SEL_W)
    ) u_ret (
        .clk    (clk),
        .por_n  (por_n),
        .wr_en  (gpr_we && ctl.cpu_clk),
        .wr_sel (gpr_sel),
        .wr_data(gpr_wdata),
        .rd_flat(gpr_rdata)
    );

    assign req_code = pwr_req_e'(req_mode);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ACTIVE;
        else        state <= state_nxt;
    end

    // Retention choices sampled when a deep request is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep_sram_q <= 1'b1;
            keep_rtc_q  <= 1'b1;
        end else if (state == ST_ACTIVE && state_nxt == ST_DEEP) begin
            keep_sram_q <= keep_sram;
            keep_rtc_q  <= keep_rtc_osc;
        end
    end

    // Transitions
    always_comb begin
        state_nxt   = state;
        settle_load = 1'b0;
        unique case (state)
            ST_ACTIVE: begin
                if (req_valid) begin
                    unique case (req_code)
                        REQ_IDLE:  if (!any_wake)     state_nxt = ST_IDLE;
                        REQ_PDOWN: if (!clkless_wake) state_nxt = ST_PDOWN;
                        REQ_DEEP:  if (!clkless_wake) state_nxt = ST_DEEP;
                        default:   state_nxt = ST_ACTIVE;
                    endcase
                end
            end
            ST_IDLE: begin
                if (any_wake) state_nxt = ST_ACTIVE;
            end
            ST_PDOWN: begin
                if (clkless_wake) begin
                    state_nxt   = ST_SETTLE;
                    settle_load = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (settle_done) state_nxt = ST_ACTIVE;
            end
            ST_DEEP: begin
                if (clkless_wake) begin
                    state_nxt   = ST_WAKE_RST;
                    settle_load = 1'b1;
                end
            end
            ST_WAKE_RST: begin
                if (settle_done) state_nxt = ST_ACTIVE;
            end
            default: state_nxt = ST_ACTIVE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_ACTIVE:   ctl = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
            ST_IDLE:     ctl = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
            ST_PDOWN:    ctl = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
            ST_SETTLE:   ctl = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
            ST_DEEP:     ctl = '{1'b0, 1'b0, 1'b0, 1'b0, keep_sram_q, keep_rtc_q, 1'b0};
            ST_WAKE_RST: ctl = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
            default:     ctl = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
        endcase
    end

    assign cpu_clk_en   = ctl.cpu_clk;
    assign per_clk_en   = ctl.per_clk;
    assign osc_en       = ctl.osc;
    assign core_pwr_en  = ctl.core_pwr;
    assign sram_ret_en  = ctl.sram_ret;
    assign rtc_osc_en   = ctl.rtc_osc;
    assign full_rst_req = ctl.rst_req;
    assign per_clk_gate = ctl.per_clk ? periph_en : '0;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
    parameter int NUM_EXT    = 3,
    parameter int NUM_IRQ    = 8,
    parameter int NUM_CAP    = 10,
    parameter int NUM_PERIPH = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [1:0]            req_mode,
    input logic [NUM_IRQ-1:0]    irq,
    input logic [NUM_CAP-1:0]    cap_irq,
    input logic [NUM_EXT-1:0]    ext_wake,
    input logic [NUM_EXT-1:0]    ext_wake_en,
    input logic                  cpu_clk_en,
    input logic                  per_clk_en,
    input logic [NUM_PERIPH-1:0] per_clk_gate,
    input logic                  osc_en,
    input logic                  core_pwr_en,
    input logic                  full_rst_req
);
    logic ext_live;
    logic irq_live;
    assign ext_live = |(ext_wake & ext_wake_en);
    assign irq_live = ext_live | (|irq) | (|cap_irq);

    p_gate_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !per_clk_en |-> (per_clk_gate == '0));

    p_no_clk_without_osc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!cpu_clk_en && !per_clk_en));

    p_core_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !core_pwr_en |-> (!cpu_clk_en && !per_clk_en && !full_rst_req));

    p_pdown_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && core_pwr_en && !ext_live) |=> (!osc_en && core_pwr_en));

    p_deep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_pwr_en && !ext_live) |=> !core_pwr_en);

    p_idle_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && per_clk_en && irq_live) |=> cpu_clk_en);

    p_entry_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && req_valid && (req_mode != 2'd0) && ext_live) |=> cpu_clk_en);

    p_idle_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && req_valid && (req_mode == 2'd1) && irq_live) |=> cpu_clk_en);

    p_osc_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> (!cpu_clk_en && !per_clk_en));

    p_reset_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full_rst_req |-> (core_pwr_en && osc_en && !cpu_clk_en));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(
    .NUM_EXT(NUM_EXT), .NUM_IRQ(NUM_IRQ), .NUM_CAP(NUM_CAP), .NUM_PERIPH(NUM_PERIPH)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_mode    (req_mode),
    .irq         (irq),
    .cap_irq     (cap_irq),
    .ext_wake    (ext_wake),
    .ext_wake_en (ext_wake_en),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .per_clk_gate(per_clk_gate),
    .osc_en      (osc_en),
    .core_pwr_en (core_pwr_en),
    .full_rst_req(full_rst_req)
);

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic        keep_sram = 1'b1;
    logic        keep_rtc_osc = 1'b1;
    logic [12:0] settle_cnt = 13'd5;
    logic [7:0]  irq = '0;
    logic [9:0]  cap_irq = '0;
    logic [2:0]  ext_wake = '0;
    logic [2:0]  ext_wake_en = '0;
    logic [7:0]  periph_en = 8'hA5;
    logic        gpr_we = 1'b0;
    logic [1:0]  gpr_sel = '0;
    logic [31:0] gpr_wdata = '0;
    logic [95:0] gpr_rdata;
    logic        cpu_clk_en, per_clk_en, osc_en, core_pwr_en;
    logic        sram_ret_en, rtc_osc_en, full_rst_req;
    logic [7:0]  per_clk_gate;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Output vector order: cpu, per, osc, core, sram, rtc, rst
    localparam logic [6:0] V_ACT    = 7'b1111110;
    localparam logic [6:0] V_IDLE   = 7'b0111110;
    localparam logic [6:0] V_PDOWN  = 7'b0001110;
    localparam logic [6:0] V_SETTLE = 7'b0011110;
    localparam logic [6:0] V_WRST   = 7'b0011111;

    always #10 clk = ~clk;

    pwr_mode_seq dut_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .req_valid(req_valid), .req_mode(req_mode),
        .keep_sram(keep_sram), .keep_rtc_osc(keep_rtc_osc),
        .settle_cnt(settle_cnt), .irq(irq), .cap_irq(cap_irq),
        .ext_wake(ext_wake), .ext_wake_en(ext_wake_en),
        .periph_en(periph_en), .gpr_we(gpr_we), .gpr_sel(gpr_sel),
        .gpr_wdata(gpr_wdata), .gpr_rdata(gpr_rdata),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .per_clk_gate(per_clk_gate), .osc_en(osc_en),
        .core_pwr_en(core_pwr_en), .sram_ret_en(sram_ret_en),
        .rtc_osc_en(rtc_osc_en), .full_rst_req(full_rst_req)
    );

    function automatic logic [6:0] outs();
        return {cpu_clk_en, per_clk_en, osc_en, core_pwr_en, sram_ret_en, rtc_osc_en, full_rst_req};
    endfunction

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic request(input logic [1:0] mode);
        req_valid = 1'b1;
        req_mode  = mode;
        @(negedge clk);
        req_valid = 1'b0;
        req_mode  = 2'd0;
    endtask

    task automatic pulse_ext(input logic [2:0] lines);
        ext_wake = lines;
        @(negedge clk);
        ext_wake = '0;
    endtask

    task automatic measure(input logic [6:0] v, output int n);
        n = 0;
        while (outs() == v && n < 6000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic gpr_write(input int sel, input logic [31:0] d);
        gpr_we = 1'b1; gpr_sel = 2'(sel); gpr_wdata = d;
        @(negedge clk);
        gpr_we = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", 96'(outs()), 96'(V_ACT));
        chk("R1 gates follow enables", 96'(per_clk_gate), 96'(periph_en));
    endtask

    task automatic t_idle();
        request(2'd1);
        chk("R3 idle outputs", 96'(outs()), 96'(V_IDLE));
        chk("R8 idle gates", 96'(per_clk_gate), 96'(8'hA5));
        request(2'd2);  // R2: ignored outside Active
        chk("R2 request ignored in idle", 96'(outs()), 96'(V_IDLE));
        cap_irq = 10'h200;
        @(negedge clk);
        cap_irq = '0;
        chk("R3 capture exits idle", 96'(outs()), 96'(V_ACT));
        request(2'd1);
        irq = 8'h10;
        @(negedge clk);
        irq = '0;
        chk("R3 irq exits idle", 96'(outs()), 96'(V_ACT));
        request(2'd0);
        chk("R2 code zero ignored", 96'(outs()), 96'(V_ACT));
    endtask

    task automatic t_pdown();
        int n;
        settle_cnt  = 13'd5;
        ext_wake_en = 3'b010;
        request(2'd2);
        chk("R4 pdown outputs", 96'(outs()), 96'(V_PDOWN));
        chk("R8 pdown gates", 96'(per_clk_gate), 96'(0));
        irq = 8'hFF; cap_irq = 10'h3FF; ext_wake = 3'b101;
        @(negedge clk);
        irq = '0; cap_irq = '0; ext_wake = '0;
        @(negedge clk);
        chk("R4 non-wake sources ignored", 96'(outs()), 96'(V_PDOWN));
        pulse_ext(3'b010);
        chk("R8 settle gates", 96'(per_clk_gate), 96'(0));
        measure(V_SETTLE, n);
        chk("R5 settle length 5", 96'(n), 96'(5));
        chk("R5 active after settle", 96'(outs()), 96'(V_ACT));
    endtask

    task automatic t_clamp();
        int n;
        settle_cnt = 13'd1;
        request(2'd2);
        pulse_ext(3'b010);
        measure(V_SETTLE, n);
        chk("R5 clamp low to 4", 96'(n), 96'(4));
        settle_cnt = 13'd6000;
        request(2'd2);
        pulse_ext(3'b010);
        measure(V_SETTLE, n);
        chk("R5 clamp high to 4096", 96'(n), 96'(4096));
        settle_cnt = 13'd5;
    endtask

    task automatic t_deep();
        int n;
        keep_sram = 1'b1; keep_rtc_osc = 1'b0;
        request(2'd3);
        chk("R6 deep outputs", 96'(outs()), 96'(7'b0000100));
        keep_sram = 1'b0; keep_rtc_osc = 1'b1;
        gpr_write(1, 32'hDEAD0000);  // R9: no write while core is off
        irq = 8'h01; cap_irq = 10'h001; ext_wake = 3'b001;
        @(negedge clk);
        irq = '0; cap_irq = '0; ext_wake = '0;
        chk("R6 retention choice sampled", 96'(outs()), 96'(7'b0000100));
        chk("R7 deep ignores non-wake", 96'(core_pwr_en), 96'(0));
        pulse_ext(3'b010);
        measure(V_WRST, n);
        chk("R7 wake reset length", 96'(n), 96'(5));
        chk("R7 active after wake reset", 96'(outs()), 96'(V_ACT));
        keep_sram = 1'b1; keep_rtc_osc = 1'b1;
    endtask

    task automatic t_blocked();
        ext_wake = 3'b010;
        request(2'd2);
        chk("R2 pdown blocked by wake", 96'(outs()), 96'(V_ACT));
        request(2'd3);
        chk("R2 deep blocked by wake", 96'(outs()), 96'(V_ACT));
        ext_wake = '0;
        irq = 8'h04;
        request(2'd1);
        irq = '0;
        chk("R2 idle blocked by irq", 96'(outs()), 96'(V_ACT));
    endtask

    task automatic t_gpr();
        gpr_write(0, 32'h11111111);
        gpr_write(1, 32'h22222222);
        gpr_write(2, 32'h33333333);
        chk("R9 gpr write", gpr_rdata, {32'h33333333, 32'h22222222, 32'h11111111});
        request(2'd1);
        gpr_write(1, 32'hBAD0BAD0);
        chk("R9 gpr write ignored in idle", 96'(gpr_rdata[63:32]), 96'(32'h22222222));
        irq = 8'h01; @(negedge clk); irq = '0;
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        chk("R9 gpr kept over reset", gpr_rdata, {32'h33333333, 32'h22222222, 32'h11111111});
    endtask

    task automatic t_gpr_deep();
        chk("R9 gpr kept over deep", gpr_rdata, {32'h33333333, 32'h22222222, 32'h11111111});
        por_n = 1'b0; #1;
        chk("R9 gpr cleared by por", gpr_rdata, 96'(0));
        @(negedge clk); por_n = 1'b1;
    endtask

    task automatic t_async_reset();
        request(2'd2);
        chk("R10 in pdown before reset", 96'(outs()), 96'(V_PDOWN));
        #3 rst_n = 1'b0;
        #1;
        chk("R10 async reset to active", 96'(outs()), 96'(V_ACT));
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        chk("R10 stays active after release", 96'(outs()), 96'(V_ACT));
    endtask

    initial begin
        t_reset();
        t_idle();
        t_pdown();
        t_clamp();
        t_blocked();
        t_gpr();
        t_deep();
        t_gpr_deep();
        t_async_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule